// File: doc/BRIEF.md
# Embedded Operations Channel Message Handler

This block moves the 12-bit maintenance message that rides in the overhead of a line superframe, in both directions. Software, or a local controller, writes the outgoing message into a transmit register in two byte-wide writes. At every half-superframe strobe, while the line reports full superframe synchronization, that register is copied into a line shift register. The framer then pulls the message out one bit per transmit bit-slot enable, so the same message goes out twice per superframe.

On the receive side, bits are collected one per receive bit-slot enable. At each half-superframe strobe the twelve collected bits form a candidate message. A candidate counts only when the line is synchronized, receive processing is enabled and exactly twelve bits have arrived since the previous strobe. An optional confirmation mode also requires the same candidate in three consecutive valid halves. An accepted message that differs from the last one reported replaces it and raises a one-cycle interrupt. The reported message stays on the `rx_msg` output.

A message is laid out as three destination address bits, one mode bit (1 = message, 0 = data) and eight information bits. It is sent and received most significant bit first.

Top module: `eoc_link`

## Requirements
- R1: A write with `wr_sel`=0 loads `wr_data[3:0]` into message bits 11:8 (address bits 11:9, mode bit 8) and ignores `wr_data[7:4]`. A write with `wr_sel`=1 loads `wr_data[7:0]` into message bits 7:0.
- R2: At a `half_sf` strobe with `sync`=1, the transmit register is loaded into the line shift register. `tx_bit` then shows message bit 11, and each `tx_slot` pulse advances to the next lower bit. After twelve slots, `tx_bit` is 1.
- R3: After reset, and in the cycle after any `deact` pulse, the transmit register holds 0xFFF. `deact` overrides a write in the same cycle.
- R4: While `sync`=0, `tx_bit` is 1. A `half_sf` strobe with `sync`=0 loads all ones into the shift register, so transmission after a later resynchronization starts only at the next strobe.
- R5: Each `rx_slot` pulse shifts `rx_bit` into the capture. The first bit received after a strobe becomes message bit 11.
- R6: When a capture is accepted and differs from `rx_msg`, then after that strobe's clock edge `rx_msg` holds the capture and `irq` is 1 for exactly one cycle. An accepted capture equal to `rx_msg` changes nothing. `rx_msg` changes only together with `irq`.
- R7: After reset, `rx_msg` is 0xFFF, `rx_is_msg` is 1 and `irq` is 0.
- R8: A capture is discarded if, at its strobe, `sync`=0, `eoc_en`=0, or the number of bits received since the previous strobe is not exactly twelve. A discarded capture leaves `rx_msg` unchanged, raises no interrupt and clears the confirmation history.
- R9: With `confirm_en`=1, a capture is accepted only if it is the third of three consecutive valid captures with identical contents. With `confirm_en`=0, every valid capture is accepted.
- R10: `rx_is_msg` equals bit 8 (the mode bit) of `rx_msg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Transmit register write strobe |
| wr_sel | input | 1 | 0 = header nibble, 1 = information byte |
| wr_data | input | 8 | Write data |
| deact | input | 1 | Deactivation or failed activation pulse |
| half_sf | input | 1 | Half-superframe strobe |
| sync | input | 1 | Line fully superframe synchronized |
| eoc_en | input | 1 | Receive processing enable |
| confirm_en | input | 1 | Three-match confirmation mode |
| tx_slot | input | 1 | Transmit bit-slot enable |
| tx_bit | output | 1 | Serial transmit bit |
| rx_slot | input | 1 | Receive bit-slot enable |
| rx_bit | input | 1 | Serial receive bit |
| irq | output | 1 | One-cycle new-message interrupt |
| rx_msg | output | 12 | Last reported received message |
| rx_is_msg | output | 1 | Mode bit of `rx_msg` |

## Verification
The assertions assume that the framer never raises `half_sf` in the same cycle as `tx_slot` or `rx_slot`, because slot enables fall strictly between strobes. They also assume that `deact` is a synchronous pulse. The stimulus keeps to this: it issues every strobe as an isolated one-cycle pulse and places all bit-slot pulses in separate cycles between strobes. Framing errors are created only by sending too few or too many slot pulses, never by overlapping them with a strobe.

// File: rtl/eoc_pkg.sv
package eoc_pkg;
  localparam int EOC_ADDR_W = 3;
  localparam int EOC_HDR_W  = EOC_ADDR_W + 1;
  localparam int EOC_INFO_W = 8;
  localparam int EOC_MSG_W  = EOC_HDR_W + EOC_INFO_W;

  typedef logic [EOC_MSG_W-1:0] eoc_msg_t;

  typedef enum logic {
    SEL_HDR  = 1'b0,
    SEL_INFO = 1'b1
  } eoc_sel_e;
endpackage

// File: rtl/eoc_rst_sync.sv
module eoc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/eoc_tx.sv
module eoc_tx
  import eoc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [EOC_INFO_W-1:0] wr_data,
  input  logic       deact,
  input  logic       half_sf,
  input  logic       sync,
  input  logic       tx_slot,
  output logic       tx_bit
);
  eoc_msg_t txr_q, txr_d;
  eoc_msg_t sh_q, sh_d;

  always_comb begin
    txr_d = txr_q;
    if (deact) begin
      txr_d = '1;
    end else if (wr_en) begin
      if (eoc_sel_e'(wr_sel) == SEL_HDR)
        txr_d[EOC_MSG_W-1:EOC_INFO_W] = wr_data[EOC_HDR_W-1:0];
      else
        txr_d[EOC_INFO_W-1:0] = wr_data;
    end
  end

  always_comb begin
    sh_d = sh_q;
    if (half_sf) begin
      sh_d = sync ? txr_q : '1;
    end else if (tx_slot) begin
      sh_d = {sh_q[EOC_MSG_W-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txr_q <= '1;
      sh_q  <= '1;
    end else begin
      txr_q <= txr_d;
      sh_q  <= sh_d;
    end
  end

  assign tx_bit = sh_q[EOC_MSG_W-1] | ~sync;

  // R3
  deact_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deact |=> (txr_q == '1));

  // R2
  sync_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_sf && sync) |=> (sh_q == $past(txr_q)));

  // R4
  idle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_sf && !sync) |=> (sh_q == '1));

  // R2
  tx_strobe_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_sf |-> !tx_slot);
endmodule

// File: rtl/eoc_rx.sv
module eoc_rx
  import eoc_pkg::*;
#(
  parameter int CONFIRM = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     half_sf,
  input  logic     sync,
  input  logic     eoc_en,
  input  logic     confirm_en,
  input  logic     rx_slot,
  input  logic     rx_bit,
  output logic     irq,
  output eoc_msg_t rx_msg
);
  localparam int CNT_W = $clog2(EOC_MSG_W + 2);
  localparam int AG_W  = (CONFIRM > 2) ? $clog2(CONFIRM) : 1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(EOC_MSG_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(EOC_MSG_W + 1);
  localparam logic [AG_W-1:0]  AG_MAX   = AG_W'(CONFIRM - 1);

  eoc_msg_t         cap_q, cap_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  eoc_msg_t         prev_q, prev_d;
  logic             prev_ok_q, prev_ok_d;
  logic [AG_W-1:0]  agree_q, agree_d;
  eoc_msg_t         msg_q, msg_d;
  logic             irq_q, irq_d;
  logic             valid, same, accept;

  assign valid  = sync && eoc_en && (cnt_q == CNT_FULL);
  assign same   = prev_ok_q && (cap_q == prev_q);

  always_comb begin
    cap_d     = cap_q;
    cnt_d     = cnt_q;
    prev_d    = prev_q;
    prev_ok_d = prev_ok_q;
    agree_d   = agree_q;
    msg_d     = msg_q;
    irq_d     = 1'b0;
    accept    = 1'b0;
    if (half_sf) begin
      cnt_d = '0;
      if (valid) begin
        if (same) agree_d = (agree_q == AG_MAX) ? agree_q : agree_q + 1'b1;
        else      agree_d = '0;
        prev_d    = cap_q;
        prev_ok_d = 1'b1;
        accept    = !confirm_en || (agree_d == AG_MAX);
        if (accept && (cap_q != msg_q)) begin
          msg_d = cap_q;
          irq_d = 1'b1;
        end
      end else begin
        prev_ok_d = 1'b0;
        agree_d   = '0;
      end
    end else if (rx_slot) begin
      cap_d = {cap_q[EOC_MSG_W-2:0], rx_bit};
      if (cnt_q != CNT_OVER) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q     <= '0;
      cnt_q     <= '0;
      prev_q    <= '0;
      prev_ok_q <= 1'b0;
      agree_q   <= '0;
      msg_q     <= '1;
      irq_q     <= 1'b0;
    end else begin
      cap_q     <= cap_d;
      cnt_q     <= cnt_d;
      prev_q    <= prev_d;
      prev_ok_q <= prev_ok_d;
      agree_q   <= agree_d;
      msg_q     <= msg_d;
      irq_q     <= irq_d;
    end
  end

  assign irq    = irq_q;
  assign rx_msg = msg_q;

  // R6
  irq_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rx_msg != $past(rx_msg)));

  // R6
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> $stable(rx_msg));

  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(half_sf && sync && eoc_en));

  // R6
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R5
  rx_strobe_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_sf |-> !rx_slot);
endmodule

// File: rtl/eoc_link.sv
module eoc_link
  import eoc_pkg::*;
#(
  parameter int CONFIRM = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [7:0]  wr_data,
  input  logic        deact,
  input  logic        half_sf,
  input  logic        sync,
  input  logic        eoc_en,
  input  logic        confirm_en,
  input  logic        tx_slot,
  output logic        tx_bit,
  input  logic        rx_slot,
  input  logic        rx_bit,
  output logic        irq,
  output logic [11:0] rx_msg,
  output logic        rx_is_msg
);
  logic rst_q_n;

  eoc_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_q_n)
  );

  eoc_tx u_tx (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .deact   (deact),
    .half_sf (half_sf),
    .sync    (sync),
    .tx_slot (tx_slot),
    .tx_bit  (tx_bit)
  );

  eoc_rx #(.CONFIRM(CONFIRM)) u_rx (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .half_sf    (half_sf),
    .sync       (sync),
    .eoc_en     (eoc_en),
    .confirm_en (confirm_en),
    .rx_slot    (rx_slot),
    .rx_bit     (rx_bit),
    .irq        (irq),
    .rx_msg     (rx_msg)
  );

  assign rx_is_msg = rx_msg[EOC_INFO_W];

  // R10
  mode_bit_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    $changed(rx_msg[EOC_INFO_W]) |-> irq);
endmodule

// File: tb/sim_eoc_link.sv
`timescale 1ns/1ps
module sim_eoc_link;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, wr_sel = 0, deact = 0, half_sf = 0, sync = 0;
  logic eoc_en = 0, confirm_en = 0, tx_slot = 0, rx_slot = 0, rx_bit = 0;
  logic [7:0]  wr_data = '0;
  logic        tx_bit, irq, rx_is_msg;
  logic [11:0] rx_msg;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [11:0] exp_msg, prev;
  bit          prev_ok, exp_irq;
  int          agree;

  always #2 clk = ~clk;

  eoc_link u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .deact(deact), .half_sf(half_sf), .sync(sync), .eoc_en(eoc_en),
    .confirm_en(confirm_en), .tx_slot(tx_slot), .tx_bit(tx_bit),
    .rx_slot(rx_slot), .rx_bit(rx_bit), .irq(irq), .rx_msg(rx_msg),
    .rx_is_msg(rx_is_msg)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d; step(); wr_en = 0;
  endtask

  task automatic strobe();
    half_sf = 1; step(); half_sf = 0;
  endtask

  // R2 R4: send and compare all twelve bits plus the idle bit
  task automatic tx_send(input logic [11:0] m, input bit s, input string req);
    sync = s;
    strobe();
    for (int b = 11; b >= 0; b--) begin
      chk(req, {11'd0, tx_bit}, {11'd0, s ? m[b] : 1'b1});
      tx_slot = 1; step(); tx_slot = 0;
    end
    chk(req, {11'd0, tx_bit}, 12'd1);
  endtask

  // R5 R6 R8 R9: one half superframe on the receive side
  task automatic rx_frame(input logic [11:0] m, input int nb, input bit s,
                          input bit en, input bit cm, input string req);
    int an;
    sync = s; eoc_en = en; confirm_en = cm;
    for (int i = 0; i < nb; i++) begin
      rx_bit = (i < 12) ? m[11-i] : 1'b0;
      rx_slot = 1; step(); rx_slot = 0;
    end
    exp_irq = 0;
    if (s && en && nb == 12) begin
      an = (prev_ok && m == prev) ? ((agree >= 2) ? 2 : agree + 1) : 0;
      agree = an; prev = m; prev_ok = 1;
      if ((!cm || an == 2) && m != exp_msg) begin
        exp_msg = m; exp_irq = 1;
      end
    end else begin
      prev_ok = 0; agree = 0;
    end
    strobe();
    chk(req, {11'd0, irq}, {11'd0, exp_irq});
    chk(req, rx_msg, exp_msg);
    chk("R10", {11'd0, rx_is_msg}, {11'd0, exp_msg[8]});
    step();
    chk({req, " one-cycle irq"}, {11'd0, irq}, 12'd0);
  endtask

  initial begin
    logic [11:0] m;
    exp_msg = 12'hFFF; prev = '0; prev_ok = 0; agree = 0;
    repeat (3) step();
    rst_n = 1;
    repeat (3) step();
    // R7 reset state
    chk("R7", rx_msg, 12'hFFF);
    chk("R7", {11'd0, irq}, 12'd0);
    chk("R7", {11'd0, rx_is_msg}, 12'd1);
    chk("R4", {11'd0, tx_bit}, 12'd1);
    // R3 reset value of transmit register
    tx_send(12'hFFF, 1, "R3");
    // R1 R2 sweep of header nibble with garbage upper bits
    for (int k = 0; k < 16; k++) begin
      m = {4'(k), 8'(k * 37 + 5)};
      wr(1'b0, {4'(k ^ 5), 4'(k)});
      wr(1'b1, m[7:0]);
      tx_send(m, 1, "R1/R2");
    end
    // R4 unsynchronized
    tx_send(m, 0, "R4");
    tx_send(m, 1, "R2");
    // R3 deact alone, then deact with write
    deact = 1; step(); deact = 0;
    tx_send(12'hFFF, 1, "R3");
    wr(1'b1, 8'h3C);
    deact = 1; wr(1'b0, 8'h02); deact = 0;
    tx_send(12'hFFF, 1, "R3");
    // R5 R6 direct mode sweep
    for (int k = 0; k < 16; k++) begin
      m = {4'(15 - k), 8'(k * 53 + 9)};
      rx_frame(m, 12, 1, 1, 0, "R5/R6");
      rx_frame(m, 12, 1, 1, 0, "R6 repeat");
    end
    // R8 discards
    rx_frame(12'h5A5, 12, 0, 1, 0, "R8 nosync");
    rx_frame(12'h5A5, 12, 1, 0, 0, "R8 disabled");
    rx_frame(12'h5A5, 11, 1, 1, 0, "R8 short");
    rx_frame(12'h5A5, 13, 1, 1, 0, "R8 long");
    // R9 confirmation
    rx_frame(12'h1E1, 12, 1, 1, 1, "R9");
    rx_frame(12'h1E1, 12, 1, 1, 1, "R9");
    rx_frame(12'h1E1, 12, 1, 1, 1, "R9 third");
    rx_frame(12'h2D2, 12, 1, 1, 1, "R9");
    rx_frame(12'h2D2, 12, 1, 1, 1, "R9");
    rx_frame(12'h2D2, 11, 1, 1, 1, "R9/R8 break");
    rx_frame(12'h2D2, 12, 1, 1, 1, "R9");
    rx_frame(12'h2D2, 12, 1, 1, 1, "R9");
    rx_frame(12'h3C3, 12, 1, 1, 1, "R9 change");
    rx_frame(12'h2D2, 12, 1, 1, 1, "R9");
    rx_frame(12'h2D2, 12, 1, 1, 1, "R9");
    rx_frame(12'h2D2, 12, 1, 1, 1, "R9 third");
    for (int k = 0; k < 6; k++)
      rx_frame(12'h0F0 + 12'(k / 3), 12, 1, 1, 1, "R9 sweep");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule